// File: doc/BRIEF.md
# Wide-Instruction Immediate and Branch Displacement Expander

This combinational unit takes the two halfwords of a 32-bit two-halfword instruction and turns their packed fields into full 32-bit values. In immediate mode it gathers the 12-bit modified-immediate field and expands it into a data-processing constant. It does this either by replicating a byte into chosen lanes or by rotating an 8-bit value that carries an implied leading one.

In branch mode it checks whether the pair belongs to the wide-branch class. It then rebuilds the sign-extended byte displacement for the conditional form or for the unconditional form. For the conditional form it also returns the condition code and a flag that is low when that code cannot be used. Adding the displacement to the program counter is left to the consumer.

Top module: `tfx_expander`

## Requirements
- R1: With `mode_i`=0, the immediate field is imm12 = {hw1_i[10], hw2_i[14:12], hw2_i[7:0]}, and b = imm12[7:0]. When imm12[11:10]=2'b00, imm12[9:8] picks the result: 0 gives b zero-extended, 1 gives b<<8, 2 gives b in bytes 3 and 1 with zeros elsewhere, and 3 gives b copied into all four bytes.
- R2: With `mode_i`=0 and imm12[11:10] not 2'b00, `imm_o` is the 32-bit value {24'b0, 1'b1, imm12[6:0]} rotated right by imm12[11:7].
- R3: With `mode_i`=1, `valid_o` is 1 only when all of the following hold: hw1_i[15:11]=5'b11110, hw2_i[15]=1, and the form code {hw2_i[14], hw2_i[12]} is 2'b00 (conditional) or 2'b01 (unconditional). With `mode_i`=0, `valid_o` is 1.
- R4: For a valid conditional form, let S = hw1_i[10]. `offset_o` holds hw2_i[13] at bit 19, hw2_i[11] at bit 18, hw1_i[5:0] at bits 17:12 and hw2_i[10:0] at bits 11:1, and it is sign-extended from bit 20, which equals S.
- R5: For a valid unconditional form, `offset_o` holds NOT(hw2_i[13] XOR S) at bit 23, NOT(hw2_i[11] XOR S) at bit 22, hw1_i[9:0] at bits 21:12 and hw2_i[10:0] at bits 11:1, and it is sign-extended from bit 24, which equals S.
- R6: For a valid conditional form, `cond_o` = hw1_i[9:6]. In every other case `cond_o` is 0. `cond_ok_o` is 1 only for a valid conditional form whose code is neither 4'b1110 nor 4'b1111.
- R7: Bit 0 of `offset_o` is always 0. `offset_o` is 0 in immediate mode and whenever `valid_o` is 0. `imm_o` is 0 in branch mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0: expand immediate, 1: decode wide branch |
| hw1_i | input | 16 | First halfword |
| hw2_i | input | 16 | Second halfword |
| imm_o | output | 32 | Expanded modified immediate |
| offset_o | output | 32 | Sign-extended branch byte displacement |
| cond_o | output | 4 | Condition code of the conditional form |
| cond_ok_o | output | 1 | Condition code is usable |
| valid_o | output | 1 | Pair is decodable in the selected mode |

## Verification
The displacement build and the condition-legality judgement can both happen for the same halfword pair. A conditional branch whose code is 4'b1110 or 4'b1111 still yields a full displacement while `cond_ok_o` drops. The bench sweeps all sixteen codes against every sign, J-bit and imm6 combination. In each case it checks both the displacement, computed arithmetically, and the legality flag, so that neither result masks a fault in the other. All 4096 immediate encodings are swept in the same way against a bench-side rotate.

// File: rtl/tfx_pkg.sv
package tfx_pkg;
  localparam int unsigned HW_W    = 16;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IMM12_W = 12;
  localparam int unsigned COND_W  = 4;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ROT_W   = $clog2(WORD_W);
  localparam int unsigned PFX_W   = 5;

  localparam logic [PFX_W-1:0] BR_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    FORM_COND   = 2'b00,
    FORM_UNCOND = 2'b01,
    FORM_RSV_A  = 2'b10,
    FORM_RSV_B  = 2'b11
  } br_form_e;

  typedef enum logic {
    MODE_IMM = 1'b0,
    MODE_BR  = 1'b1
  } mode_e;
endpackage

// File: rtl/tfx_mod_imm.sv
module tfx_mod_imm
  import tfx_pkg::*;
(
  input  logic [IMM12_W-1:0] imm12_i,
  output logic [WORD_W-1:0]  value_o
);
  logic [BYTE_W-1:0]   b;
  logic [ROT_W-1:0]    rot;
  logic [WORD_W-1:0]   base;
  logic [2*WORD_W-1:0] dbl;

  always_comb begin
    b    = imm12_i[BYTE_W-1:0];
    rot  = imm12_i[IMM12_W-1:IMM12_W-ROT_W];
    base = WORD_W'({1'b1, imm12_i[6:0]});
    // rotate right via doubled word
    dbl  = {base, base} >> rot;
    if (imm12_i[11:10] == 2'b00) begin
      unique case (imm12_i[9:8])
        2'd0:    value_o = WORD_W'(b);
        2'd1:    value_o = WORD_W'({b, 8'h00});
        2'd2:    value_o = {b, 8'h00, b, 8'h00};
        default: value_o = {b, b, b, b};
      endcase
    end else begin
      value_o = dbl[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/tfx_branch_disp.sv
module tfx_branch_disp
  import tfx_pkg::*;
(
  input  logic [HW_W-1:0]   hw1_i,
  input  logic [HW_W-1:0]   hw2_i,
  output logic              hit_o,
  output logic              is_cond_o,
  output logic [WORD_W-1:0] disp_o
);
  logic              s, j1, j2, in_class;
  br_form_e          form;
  logic [WORD_W-1:0] disp_c, disp_u;

  always_comb begin
    s        = hw1_i[10];
    j1       = hw2_i[13];
    j2       = hw2_i[11];
    form     = br_form_e'({hw2_i[14], hw2_i[12]});
    in_class = (hw1_i[15:11] == BR_PREFIX) && hw2_i[15];
    disp_c   = {{11{s}}, s, j1, j2, hw1_i[5:0], hw2_i[10:0], 1'b0};
    disp_u   = {{7{s}}, s, ~(j1 ^ s), ~(j2 ^ s), hw1_i[9:0], hw2_i[10:0], 1'b0};
    hit_o     = 1'b0;
    is_cond_o = 1'b0;
    disp_o    = '0;
    if (in_class) begin
      unique case (form)
        FORM_COND: begin
          hit_o     = 1'b1;
          is_cond_o = 1'b1;
          disp_o    = disp_c;
        end
        FORM_UNCOND: begin
          hit_o  = 1'b1;
          disp_o = disp_u;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tfx_cond_gate.sv
module tfx_cond_gate
  import tfx_pkg::*;
(
  input  logic              en_i,
  input  logic [COND_W-1:0] code_i,
  output logic [COND_W-1:0] cond_o,
  output logic              ok_o
);
  always_comb begin
    cond_o = en_i ? code_i : '0;
    // always / never codes are unusable here
    ok_o   = en_i && (code_i[3:1] != 3'b111);
  end
endmodule

// File: rtl/tfx_expander.sv
module tfx_expander
  import tfx_pkg::*;
(
  input  logic              mode_i,
  input  logic [HW_W-1:0]   hw1_i,
  input  logic [HW_W-1:0]   hw2_i,
  output logic [WORD_W-1:0] imm_o,
  output logic [WORD_W-1:0] offset_o,
  output logic [COND_W-1:0] cond_o,
  output logic              cond_ok_o,
  output logic              valid_o
);
  logic [IMM12_W-1:0] imm12;
  logic [WORD_W-1:0]  imm_val, disp;
  logic               br_hit, br_cond, br_mode;

  assign imm12   = {hw1_i[10], hw2_i[14:12], hw2_i[7:0]};
  assign br_mode = (mode_e'(mode_i) == MODE_BR);

  tfx_mod_imm u_imm (
    .imm12_i (imm12),
    .value_o (imm_val)
  );

  tfx_branch_disp u_br (
    .hw1_i     (hw1_i),
    .hw2_i     (hw2_i),
    .hit_o     (br_hit),
    .is_cond_o (br_cond),
    .disp_o    (disp)
  );

  tfx_cond_gate u_cond (
    .en_i   (br_mode && br_cond),
    .code_i (hw1_i[9:6]),
    .cond_o (cond_o),
    .ok_o   (cond_ok_o)
  );

  assign imm_o    = br_mode ? '0 : imm_val;
  assign offset_o = br_mode ? disp : '0;
  assign valid_o  = br_mode ? br_hit : 1'b1;
endmodule

// File: rtl/tfx_checker.sv
module tfx_checker
  import tfx_pkg::*;
(
  input logic              mode_i,
  input logic [HW_W-1:0]   hw1_i,
  input logic [HW_W-1:0]   hw2_i,
  input logic [WORD_W-1:0] imm_o,
  input logic [WORD_W-1:0] offset_o,
  input logic [COND_W-1:0] cond_o,
  input logic              cond_ok_o,
  input logic              valid_o
);
  logic [IMM12_W-1:0] imm12;
  logic [1:0]         form;
  int                 lanes;

  always_comb begin
    imm12 = {hw1_i[10], hw2_i[14:12], hw2_i[7:0]};
    form  = {hw2_i[14], hw2_i[12]};
    case (imm12[9:8])
      2'd0, 2'd1: lanes = 1;
      2'd2:       lanes = 2;
      default:    lanes = 4;
    endcase

    p_pat_pop_r1: assert (mode_i || imm12[11:10] != 2'b00 ||
                          $countones(imm_o) == lanes * $countones(imm12[7:0]))
      else $error("pattern popcount");
    p_rot_pop_r2: assert (mode_i || imm12[11:10] == 2'b00 ||
                          $countones(imm_o) == 1 + $countones(imm12[6:0]))
      else $error("rotate popcount");
    p_class_r3: assert (!(mode_i && valid_o) ||
                        (hw1_i[15:11] == 5'b11110 && hw2_i[15] && !form[1]))
      else $error("valid outside class");
    p_imm_valid_r3: assert (mode_i || valid_o)
      else $error("immediate mode invalid");
    p_cond_sext_r4: assert (!(mode_i && valid_o && form == 2'b00) ||
                            offset_o[31:20] == {12{hw1_i[10]}})
      else $error("cond sign extension");
    p_unc_sext_r5: assert (!(mode_i && valid_o && form == 2'b01) ||
                           offset_o[31:24] == {8{hw1_i[10]}})
      else $error("uncond sign extension");
    p_cond_ok_r6: assert (!cond_ok_o || (valid_o && mode_i && cond_o[3:1] != 3'b111))
      else $error("unusable cond flagged ok");
    p_bit0_r7: assert (offset_o[0] == 1'b0)
      else $error("odd offset");
    p_off_zero_r7: assert ((mode_i && valid_o) || offset_o == '0)
      else $error("stray offset");
    p_imm_zero_r7: assert (!mode_i || imm_o == '0)
      else $error("stray immediate");
  end
endmodule

bind tfx_expander tfx_checker u_chk (
  .mode_i    (mode_i),
  .hw1_i     (hw1_i),
  .hw2_i     (hw2_i),
  .imm_o     (imm_o),
  .offset_o  (offset_o),
  .cond_o    (cond_o),
  .cond_ok_o (cond_ok_o),
  .valid_o   (valid_o)
);

// File: tb/tfx_expander_tb_top.sv
module tfx_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode;
  logic [15:0] hw1, hw2;
  logic [31:0] imm, off;
  logic [3:0]  cond;
  logic        cond_ok, valid;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tfx_expander dut_i (
    .mode_i (mode), .hw1_i (hw1), .hw2_i (hw2),
    .imm_o (imm), .offset_o (off), .cond_o (cond),
    .cond_ok_o (cond_ok), .valid_o (valid)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s m=%0d hw1=%h hw2=%h got=%h exp=%h", req, mode, hw1, hw2, got, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    mode = m; hw1 = a; hw2 = b;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_imm(input int v);
    logic [31:0] b, x;
    int          r;
    b = 32'(v & 255);
    if (((v >> 10) & 3) == 0) begin
      case ((v >> 8) & 3)
        0:       x = b;
        1:       x = b * 32'h100;
        2:       x = b * 32'h0100_0100;
        default: x = b * 32'h0101_0101;
      endcase
    end else begin
      x = 32'(128 + (v & 127));
      r = (v >> 7) & 31;
      x = (x >> r) | (x << (32 - r));
    end
    return x;
  endfunction

  localparam logic [10:0] IMM11_SET [3] = '{11'h000, 11'h555, 11'h7FF};

  initial begin
    mode = 1'b0; hw1 = '0; hw2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset imm", imm, 32'h0);
    chk("R3 reset valid", 32'(valid), 32'd1);
    chk("R7 reset offset", off, 32'h0);
    rst_n = 1'b1;

    // R1 / R2: all immediate encodings, noise in unused bits
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] f;
      f = 12'(v);
      apply(1'b0, {5'b11110, f[11], f[9:0] ^ 10'h2A5}, {1'b1, f[10:8], 4'hC, f[7:0]});
      chk(f[11:10] == 2'b00 ? "R1 pattern" : "R2 rotate", imm, exp_imm(v));
      chk("R3 imm mode valid", 32'(valid), 32'd1);
      chk("R7 imm mode offset", off, 32'h0);
    end

    // R4 / R6: conditional form, every code
    for (int s = 0; s < 2; s++)
      for (int j = 0; j < 4; j++)
        for (int i6 = 0; i6 < 64; i6++)
          for (int c = 0; c < 16; c++)
            for (int k = 0; k < 3; k++) begin
              logic [31:0] e;
              e = 32'((j >> 1) * (1 << 19) + (j & 1) * (1 << 18) + i6 * (1 << 12)
                      + int'(IMM11_SET[k]) * 2);
              if (s == 1) e = e - 32'h0010_0000;
              apply(1'b1, {5'b11110, 1'(s), 4'(c), 6'(i6)},
                    {1'b1, 1'b0, 1'(j >> 1), 1'b0, 1'(j), IMM11_SET[k]});
              chk("R4 cond offset", off, e);
              chk("R3 cond valid", 32'(valid), 32'd1);
              chk("R6 cond code", 32'(cond), 32'(c));
              chk("R6 cond ok", 32'(cond_ok), (c < 14) ? 32'd1 : 32'd0);
              chk("R7 branch imm", imm, 32'h0);
            end

    // R5: unconditional form
    for (int s = 0; s < 2; s++)
      for (int j = 0; j < 4; j++)
        for (int t = 0; t < 32; t++)
          for (int k = 0; k < 3; k++) begin
            logic [31:0] e;
            int i1, i2, i10;
            i10 = (t == 31) ? 1023 : t * 33;
            i1 = ((j >> 1) == s) ? 1 : 0;
            i2 = ((j & 1) == s) ? 1 : 0;
            e = 32'(i1 * (1 << 23) + i2 * (1 << 22) + i10 * (1 << 12) + int'(IMM11_SET[k]) * 2);
            if (s == 1) e = e - 32'h0100_0000;
            apply(1'b1, {5'b11110, 1'(s), 10'(i10)},
                  {1'b1, 1'b0, 1'(j >> 1), 1'b1, 1'(j), IMM11_SET[k]});
            chk("R5 uncond offset", off, e);
            chk("R3 uncond valid", 32'(valid), 32'd1);
            chk("R6 uncond cond", 32'(cond), 32'h0);
            chk("R6 uncond ok", 32'(cond_ok), 32'h0);
          end

    // R3: pairs outside the class
    for (int p = 0; p < 32; p++) begin
      if (p == 5'b11110) continue;
      apply(1'b1, {5'(p), 11'h3FF}, 16'hAFFF);
      chk("R3 prefix reject", 32'(valid), 32'd0);
      chk("R7 reject offset", off, 32'h0);
      chk("R6 reject ok", 32'(cond_ok), 32'd0);
    end
    for (int f = 2; f < 4; f++) begin
      apply(1'b1, 16'hF7C1, {1'b1, 1'(f >> 1), 1'b1, 1'(f), 12'hFFF});
      chk("R3 form reject", 32'(valid), 32'd0);
      chk("R7 form reject offset", off, 32'h0);
      chk("R6 form reject cond", 32'(cond), 32'h0);
    end
    apply(1'b1, 16'hF40F, 16'h2ABC);
    chk("R3 hw2 bit15 reject", 32'(valid), 32'd0);
    chk("R7 hw2 bit15 offset", off, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule